// File: doc/BRIEF.md
# Serial Shift-Register I/O Scanner

This block is a scan master for two daisy-chained serial shift-register chains built from 8-bit stages. One chain is made of parallel-in/serial-out stages and collects input pins. The other is made of serial-in/parallel-out stages and drives output pins. Both chains hang off the same pair of control lines, a shift clock and a latch strobe, while each chain has its own data line. On every scan tick the block pulses the latch to freeze the input pins. It then walks every bit position of the active stages: it reads the returning serial bit, presents the next outgoing bit, and pulses the shift clock. A last latch pulse moves the shifted-in output pattern onto the output pins.

The host writes an output image of up to 16 bytes and reads an input image of the same size. A prescaler makes the scan tick from the system clock, which gives one scan per millisecond at the default setting. A second divider sets the width of each shift-clock and latch phase. The number of active stages per chain is a runtime input. Positions beyond it get no clock edges, so a shorter chain scans in fewer cycles. The output image is frozen into a shadow copy when a scan starts. A host write that lands during a scan therefore shows up only in the next scan.

Top module: `sreg_scanner`

## Requirements
- R1: While reset is asserted and until the first scan starts, sr_shift_clk, sr_latch, scan_done and busy are 0, and every input image byte reads 0.
- R2: A scan starts every TICK_DIV clock cycles, so consecutive scan_done pulses are exactly TICK_DIV cycles apart.
- R3: Each scan issues exactly two latch pulses, one before the first shift-clock pulse and one after the last. The latch and the shift clock are never high in the same cycle.
- R4: A scan issues exactly 8 x (effective stage count) shift-clock pulses. No shift-clock or latch pulse occurs while busy is 0.
- R5: Bit positions are numbered k = 0, 1, 2, ... in scan order. The serial input bit for position k is sampled before the shift pulse of position k, and it is stored in input image byte k/8 at bit 7 - (k mod 8). The first sampled bit therefore lands in bit 7 of byte 0.
- R6: The output bit for position k comes from output image byte k/8, bit 7 - (k mod 8). It is held on sr_dout for the whole time the shift clock is high.
- R7: The stage count is sampled at scan start. A value of 0 counts as 1, and any value above MAX_REGS counts as MAX_REGS.
- R8: Input image bytes at or beyond the effective stage count keep their previous contents through a scan.
- R9: The output image is copied at scan start. A host write made while busy is 1 does not change the bits shifted out in that scan, and it does take effect in the next scan.
- R10: scan_done is high for exactly one cycle. That cycle directly follows the last cycle of the final latch pulse.
- R11: Every shift-clock high phase lasts exactly HALF_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_nregs | input | 5 | Active 8-bit stages per chain, sampled at scan start |
| host_out_we | input | 1 | Write strobe for one output image byte |
| host_out_idx | input | 4 | Output image byte index |
| host_out_data | input | 8 | Output image write data |
| host_in_idx | input | 4 | Input image byte index for reading |
| host_in_data | output | 8 | Input image byte selected by host_in_idx |
| sr_din | input | 1 | Serial data returning from the input chain |
| sr_shift_clk | output | 1 | Shift clock shared by both chains |
| sr_latch | output | 1 | Latch strobe shared by both chains |
| sr_dout | output | 1 | Serial data into the output chain |
| scan_done | output | 1 | One-cycle pulse at the end of each scan |
| busy | output | 1 | High while a scan is in progress |

## Verification
The hardest case to reach from the ports is a host write that lands inside a running scan. The write has to change the live image and leave the shadow copy alone. The bench waits until busy rises, writes a new byte in that window, and then checks two things: the output pins of a behavioural chain model show the old byte after that scan, and they show the new byte after the next scan. That same chain model reacts to the shift and latch edges the way real shift stages do, so bit ordering and the sample-then-shift sequence are checked from the pin activity alone. Short chains, out-of-range stage counts and untouched upper input bytes are covered by rescanning with different counts.

// File: rtl/sreg_scan_pkg.sv
package sreg_scan_pkg;

  localparam int unsigned BITS_PER_STAGE = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH_IN,
    ST_SAMPLE,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_LATCH_OUT,
    ST_DONE
  } scan_state_e;

endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
  parameter int unsigned TICK_DIV = 250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == TW'(TICK_DIV - 1));
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;
endmodule

// File: rtl/shift_pacer.sv
module shift_pacer #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic phase_end
);
  localparam int unsigned PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;

  always_comb begin
    phase_end = en && (cnt_q == PW'(HALF_DIV - 1));
    cnt_d     = (en && !phase_end) ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import sreg_scan_pkg::*;
#(
  parameter int unsigned MAX_REGS = 16,
  localparam int unsigned NBITS   = MAX_REGS * BITS_PER_STAGE,
  localparam int unsigned IW      = $clog2(NBITS),
  localparam int unsigned CW      = $clog2(MAX_REGS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          phase_end,
  input  logic [CW-1:0] cfg_nregs,
  output logic          pace_en,
  output logic          snap_load,
  output logic          sample_we,
  output logic [IW-1:0] bit_idx,
  output logic          sr_shift_clk,
  output logic          sr_latch,
  output logic          scan_done,
  output logic          busy
);
  scan_state_e   state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] last_q, last_d;
  logic [CW-1:0] eff_cnt;
  logic [CW+2:0] eff_bits;

  // Effective stage count: clamp into 1..MAX_REGS.
  always_comb begin
    if (cfg_nregs == '0)                  eff_cnt = CW'(1);
    else if (cfg_nregs > CW'(MAX_REGS))   eff_cnt = CW'(MAX_REGS);
    else                                  eff_cnt = cfg_nregs;
    eff_bits = {eff_cnt, 3'b000} - 1'b1;
  end

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    last_d    = last_q;
    snap_load = 1'b0;
    sample_we = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tick) begin
          snap_load = 1'b1;
          idx_d     = '0;
          last_d    = IW'(eff_bits);
          state_d   = ST_LATCH_IN;
        end
      end
      ST_LATCH_IN: begin
        if (phase_end) state_d = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        sample_we = 1'b1;
        state_d   = ST_BIT_LO;
      end
      ST_BIT_LO: begin
        if (phase_end) state_d = ST_BIT_HI;
      end
      ST_BIT_HI: begin
        if (phase_end) begin
          if (idx_q == last_q) begin
            state_d = ST_LATCH_OUT;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_SAMPLE;
          end
        end
      end
      ST_LATCH_OUT: begin
        if (phase_end) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
    end
  end

  // Pin controls decode directly from the state flops.
  always_comb begin
    pace_en      = (state_q == ST_LATCH_IN) || (state_q == ST_BIT_LO) ||
                   (state_q == ST_BIT_HI)   || (state_q == ST_LATCH_OUT);
    sr_shift_clk = (state_q == ST_BIT_HI);
    sr_latch     = (state_q == ST_LATCH_IN) || (state_q == ST_LATCH_OUT);
    scan_done    = (state_q == ST_DONE);
    busy         = (state_q != ST_IDLE);
    bit_idx      = idx_q;
  end
endmodule

// File: rtl/scan_image.sv
module scan_image
  import sreg_scan_pkg::*;
#(
  parameter int unsigned MAX_REGS = 16,
  localparam int unsigned NBITS   = MAX_REGS * BITS_PER_STAGE,
  localparam int unsigned IW      = $clog2(NBITS),
  localparam int unsigned RW      = $clog2(MAX_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [RW-1:0] host_widx,
  input  logic [7:0]    host_wdata,
  input  logic [RW-1:0] host_ridx,
  output logic [7:0]    host_rdata,
  input  logic          snap_load,
  input  logic          sample_we,
  input  logic [IW-1:0] bit_idx,
  input  logic          din,
  output logic          dout
);
  // Flat storage: byte r bit b sits at r*8+b. Scan position k maps to
  // byte k/8 bit 7-(k%8), i.e. the low three index bits inverted.
  logic [NBITS-1:0] out_q, out_d;
  logic [NBITS-1:0] snap_q, snap_d;
  logic [NBITS-1:0] in_q, in_d;
  logic             dout_q, dout_d;
  logic [IW-1:0]    pos;
  logic [RW+2:0]    wbase;
  logic [RW+2:0]    rbase;

  always_comb begin
    pos   = {bit_idx[IW-1:3], ~bit_idx[2:0]};
    wbase = {host_widx, 3'b000};
    rbase = {host_ridx, 3'b000};

    out_d = out_q;
    if (host_we && ({1'b0, host_widx} < (RW+1)'(MAX_REGS)))
      out_d[wbase +: 8] = host_wdata;

    snap_d = snap_load ? out_q : snap_q;

    in_d   = in_q;
    dout_d = dout_q;
    if (sample_we) begin
      in_d[pos] = din;
      dout_d    = snap_q[pos];
    end

    if ({1'b0, host_ridx} < (RW+1)'(MAX_REGS)) host_rdata = in_q[rbase +: 8];
    else                                        host_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      snap_q <= '0;
      in_q   <= '0;
      dout_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      snap_q <= snap_d;
      in_q   <= in_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/sreg_scanner.sv
module sreg_scanner
  import sreg_scan_pkg::*;
#(
  parameter int unsigned MAX_REGS = 16,
  parameter int unsigned TICK_DIV = 250000,
  parameter int unsigned HALF_DIV = 2,
  localparam int unsigned NBITS   = MAX_REGS * BITS_PER_STAGE,
  localparam int unsigned IW      = $clog2(NBITS),
  localparam int unsigned RW      = $clog2(MAX_REGS),
  localparam int unsigned CW      = $clog2(MAX_REGS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_nregs,
  input  logic          host_out_we,
  input  logic [RW-1:0] host_out_idx,
  input  logic [7:0]    host_out_data,
  input  logic [RW-1:0] host_in_idx,
  output logic [7:0]    host_in_data,
  input  logic          sr_din,
  output logic          sr_shift_clk,
  output logic          sr_latch,
  output logic          sr_dout,
  output logic          scan_done,
  output logic          busy
);
  logic [1:0]    rsync_q;
  logic          core_rst_n;
  logic          tick;
  logic          phase_end;
  logic          pace_en;
  logic          snap_load;
  logic          sample_we;
  logic [IW-1:0] bit_idx;

  // Reset asserts asynchronously, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  scan_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (core_rst_n),
    .tick  (tick)
  );

  shift_pacer #(.HALF_DIV(HALF_DIV)) u_pacer (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .en        (pace_en),
    .phase_end (phase_end)
  );

  scan_sequencer #(.MAX_REGS(MAX_REGS)) u_seq (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .tick         (tick),
    .phase_end    (phase_end),
    .cfg_nregs    (cfg_nregs),
    .pace_en      (pace_en),
    .snap_load    (snap_load),
    .sample_we    (sample_we),
    .bit_idx      (bit_idx),
    .sr_shift_clk (sr_shift_clk),
    .sr_latch     (sr_latch),
    .scan_done    (scan_done),
    .busy         (busy)
  );

  scan_image #(.MAX_REGS(MAX_REGS)) u_img (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .host_we    (host_out_we),
    .host_widx  (host_out_idx),
    .host_wdata (host_out_data),
    .host_ridx  (host_in_idx),
    .host_rdata (host_in_data),
    .snap_load  (snap_load),
    .sample_we  (sample_we),
    .bit_idx    (bit_idx),
    .din        (sr_din),
    .dout       (sr_dout)
  );
endmodule

// File: rtl/sreg_scanner_chk.sv
module sreg_scanner_chk #(
  parameter int unsigned HALF_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic sr_shift_clk,
  input logic sr_latch,
  input logic sr_dout,
  input logic scan_done,
  input logic busy
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hi_cnt <= '0;
    else if (sr_shift_clk) hi_cnt <= hi_cnt + 1'b1;
    else                   hi_cnt <= '0;
  end

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_shift_clk && sr_latch));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sr_shift_clk && !sr_latch));

  a_r6_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sr_shift_clk |-> $stable(sr_dout));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  a_r10_done_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> ($past(sr_latch) && !sr_latch));

  a_r11_high_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_shift_clk) |-> (hi_cnt == 16'(HALF_DIV)));
endmodule

bind sreg_scanner sreg_scanner_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sr_shift_clk (sr_shift_clk),
  .sr_latch     (sr_latch),
  .sr_dout      (sr_dout),
  .scan_done    (scan_done),
  .busy         (busy)
);

// File: tb/test_sreg_scanner.sv
module test_sreg_scanner;
  localparam int TICK = 1000;
  localparam int HALF = 2;
  localparam int MAXR = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cfg_nregs = 5'd16;
  logic       host_out_we = 1'b0;
  logic [3:0] host_out_idx = '0;
  logic [7:0] host_out_data = '0;
  logic [3:0] host_in_idx = '0;
  logic [7:0] host_in_data;
  logic       sr_din;
  logic       sr_shift_clk, sr_latch, sr_dout, scan_done, busy;

  always #2 clk = ~clk;

  sreg_scanner #(.MAX_REGS(MAXR), .TICK_DIV(TICK), .HALF_DIV(HALF)) i_sreg_scanner (
    .clk(clk), .rst_n(rst_n), .cfg_nregs(cfg_nregs),
    .host_out_we(host_out_we), .host_out_idx(host_out_idx), .host_out_data(host_out_data),
    .host_in_idx(host_in_idx), .host_in_data(host_in_data),
    .sr_din(sr_din), .sr_shift_clk(sr_shift_clk), .sr_latch(sr_latch),
    .sr_dout(sr_dout), .scan_done(scan_done), .busy(busy)
  );

  // Behavioural chain model: PISO input stages and SIPO output stages.
  logic [127:0] piso = '0;
  logic [127:0] sipo = '0;
  logic [127:0] pins_out = '0;
  logic [7:0]   pins_in [MAXR];
  logic [7:0]   oimg [MAXR];
  int shift_cnt = 0;
  int latch_cnt = 0;

  assign sr_din = piso[0];

  always @(posedge sr_latch) begin
    for (int k = 0; k < 128; k++) piso[k] = pins_in[k / 8][7 - (k % 8)];
    pins_out = sipo;
    latch_cnt++;
  end

  always @(posedge sr_shift_clk) begin
    piso = {1'b0, piso[127:1]};
    sipo = {sipo[126:0], sr_dout};
    shift_cnt++;
  end

  longint cyc = 0;
  always @(posedge clk) cyc++;

  int hi_run = 0, last_hi = 0;
  bit prev_latch = 1'b0, done_prev_latch = 1'b0, done_cur_latch = 1'b1;
  always @(negedge clk) begin
    if (sr_shift_clk) hi_run++;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
    if (scan_done) begin done_prev_latch = prev_latch; done_cur_latch = sr_latch; end
    prev_latch = sr_latch;
  end

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!scan_done) @(negedge clk);
  endtask

  task automatic scan_pass();
    wait_done();
    shift_cnt = 0;
    latch_cnt = 0;
    wait_done();
  endtask

  task automatic write_out(input int r, input logic [7:0] v);
    @(negedge clk);
    host_out_we = 1'b1; host_out_idx = 4'(r); host_out_data = v;
    @(negedge clk);
    host_out_we = 1'b0;
    oimg[r] = v;
  endtask

  task automatic read_in(input int r, output logic [7:0] v);
    host_in_idx = 4'(r);
    #1;
    v = host_in_data;
  endtask

  function automatic logic [7:0] out_byte(input int n, input int r);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = pins_out[n * 8 - 1 - (r * 8 + 7 - b)];
    return v;
  endfunction

  task automatic check_in(input int lo, input int hi, input string req);
    logic [7:0] v;
    for (int r = lo; r < hi; r++) begin
      read_in(r, v);
      chk(req, $sformatf("input byte %0d", r), 64'(v), 64'(pins_in[r]));
    end
  endtask

  task automatic check_out(input int n, input string req);
    for (int r = 0; r < n; r++)
      chk(req, $sformatf("output pins byte %0d", r), 64'(out_byte(n, r)), 64'(oimg[r]));
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1", "shift clk", 64'(sr_shift_clk), 64'd0);
    chk("R1", "latch", 64'(sr_latch), 64'd0);
    chk("R1", "scan_done", 64'(scan_done), 64'd0);
    chk("R1", "busy", 64'(busy), 64'd0);
    read_in(5, v);
    chk("R1", "input byte 5", 64'(v), 64'd0);
  endtask

  task automatic t_full_chain();
    cfg_nregs = 5'd16;
    for (int r = 0; r < MAXR; r++) begin
      pins_in[r] = 8'(r * 29 + 11);
      write_out(r, 8'(r * 37 + 5) ^ 8'h5A);
    end
    scan_pass();
    chk("R4", "shift pulses n=16", 64'(shift_cnt), 64'd128);
    chk("R3", "latch pulses", 64'(latch_cnt), 64'd2);
    chk("R11", "shift high width", 64'(last_hi), 64'(HALF));
    check_in(0, MAXR, "R5");
    check_out(16, "R6");
  endtask

  task automatic t_short_chain();
    logic [7:0] old_in [MAXR];
    for (int r = 0; r < MAXR; r++) begin old_in[r] = pins_in[r]; pins_in[r] = ~pins_in[r]; end
    cfg_nregs = 5'd3;
    write_out(1, 8'h81);
    scan_pass();
    chk("R4", "shift pulses n=3", 64'(shift_cnt), 64'd24);
    check_in(0, 3, "R5");
    check_out(3, "R6");
    for (int r = 3; r < MAXR; r++) pins_in[r] = old_in[r];
    check_in(3, MAXR, "R8");
  endtask

  task automatic t_clamp();
    cfg_nregs = 5'd0;
    scan_pass();
    chk("R7", "shift pulses cfg=0", 64'(shift_cnt), 64'd8);
    check_out(1, "R7");
    cfg_nregs = 5'd31;
    scan_pass();
    chk("R7", "shift pulses cfg=31", 64'(shift_cnt), 64'd128);
  endtask

  task automatic t_no_tear();
    cfg_nregs = 5'd2;
    write_out(0, 8'h3C);
    scan_pass();
    @(negedge clk);
    while (!busy) @(negedge clk);
    write_out(0, 8'hC3);
    chk("R9", "write landed during scan", 64'(busy), 64'd1);
    wait_done();
    chk("R9", "scan after mid-scan write", 64'(out_byte(2, 0)), 64'h3C);
    wait_done();
    chk("R9", "following scan", 64'(out_byte(2, 0)), 64'hC3);
  endtask

  task automatic t_period();
    longint c0;
    wait_done();
    c0 = cyc;
    wait_done();
    chk("R2", "scan period", 64'(cyc - c0), 64'(TICK));
    chk("R10", "latch high before done", 64'(done_prev_latch), 64'd1);
    chk("R10", "latch low at done", 64'(done_cur_latch), 64'd0);
    @(negedge clk);
    chk("R10", "done one cycle", 64'(scan_done), 64'd0);
  endtask

  initial begin
    for (int r = 0; r < MAXR; r++) begin pins_in[r] = '0; oimg[r] = '0; end
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_chain();
    t_short_chain();
    t_clamp();
    t_no_tear();
    t_period();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule